// File: doc/BRIEF.md
# Zoned External Memory Bus Controller

This block turns single accesses from an internal request port into timed cycles on an asynchronous external memory bus with a 19-bit address and a 16-bit data path. Each request names a target zone: 0, 1, 2, 6 or 7. The zones share three active-low chip selects. Every zone has its own strobe timing, split into three phases: a set-up phase, a strobe-low phase and a hold-off phase. Every zone can also be set to stretch its strobe until an external ready input is high. That ready input can be taken directly or through a two-flop synchronizer.

An external master can take over the bus with an active-low hold request. The controller first finishes the access in progress and any request already waiting. It then floats its address, data, select and strobe outputs and grants the bus with an active-low acknowledge. Requests that arrive while the bus is granted wait at the port and are served after release. A divided copy of the system clock is driven out for external wait-state logic. A mode bit that enables zone 7 is taken from a pin during reset and can be rewritten later.

The controller is one state machine with five states:
- IDLE: the bus is at rest.
- LEAD: select asserted, strobe high.
- ACTIVE: strobe low.
- TRAIL: strobe high again, select still asserted.
- HOLD: bus granted away.

Transitions:
- IDLE→LEAD: a request to an enabled zone is accepted.
- IDLE→IDLE: a request to an invalid or disabled zone is answered at once.
- IDLE→HOLD: a hold request is seen and no request is waiting.
- LEAD→ACTIVE: the set-up count has expired.
- ACTIVE→TRAIL: the strobe count has expired and ready is satisfied.
- TRAIL→IDLE: the hold-off count has expired; this produces the response.
- HOLD→IDLE: the synchronized hold request has been withdrawn.

Top module: `zbus_ext_if`

## Requirements
- R1: After reset the bus is at rest: all selects, both strobes, read-not-write and the grant are high, the control output enable is 1, the data output enable is 0, the request port is ready and no response is pending.
- R2: `req_zone` carries the zone number in binary. Zones 0 and 1 drive `ext_cs_n[0]` low, zone 2 drives `ext_cs_n[1]` low and zones 6 and 7 drive `ext_cs_n[2]` low, never more than one at a time. Codes 3, 4 and 5 assert no select and return a response with data 0 one cycle after acceptance.
- R3: Each zone uses a 3-bit field v in each of `cfg_lead`, `cfg_active` and `cfg_trail`. Zones 0, 1, 2, 6 and 7 use fields 0 to 4, and field i sits in bits [3i+2:3i]. The LEAD, ACTIVE and TRAIL phases last v+1 system clocks each, so no phase is ever shorter than one clock.
- R4: Read cycles pull only `ext_rd_n` low and write cycles pull only `ext_wr_n` low, and only during ACTIVE. The two strobes are never low together.
- R5: `ext_rnw` is low throughout every phase of a write cycle and high at all other times.
- R6: During a cycle `ext_a` carries the request address. `ext_d_oe` is 1 exactly during the phases of a write cycle, with `ext_d_out` equal to the write data.
- R7: A read captures `ext_d_in` in the last ACTIVE clock. `rsp_valid` pulses for one cycle, in the cycle after the last TRAIL clock, with that value on `rsp_rdata`.
- R8: When a zone's bit in `cfg_use_rdy` is 1, ACTIVE is extended past its count while ready is low. With that zone's `cfg_rdy_async` bit at 0, ready is used in the same cycle. With the bit at 1, ready passes through two flops first, so the strobe lasts two clocks longer. When the use bit is 0, ready is ignored.
- R9: A low `ext_hold_n` is acted on only after the current access and any waiting request are complete. The controller then drives `ext_holda_n` low and sets `ext_ctl_oe` and `ext_d_oe` to 0. While the bus is granted, `req_ready` stays low and no select is asserted. A request left waiting is served after release.
- R10: `ext_holda_n` returns high three clocks after `ext_hold_n` goes high: two clocks in the synchronizer and one in the state register.
- R11: `ext_bclk` is the system clock, half of it or a quarter of it when the clock division setting is 0, 1 or 2 respectively. The setting resets to a quarter. With the clock-off bit set, `ext_bclk` is held low.
- R12: The zone 7 enable bit loads from `mode_pin` while reset is low and is rewritten by `mode_we`. While it is 0, zone 7 requests behave like invalid codes (R2) and zone 6 is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_ready | output | 1 | Request accepted on this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_zone | input | 3 | Target zone number |
| req_addr | input | 19 | Address within the external bus |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data |
| cfg_lead | input | 15 | Per-zone set-up length fields |
| cfg_active | input | 15 | Per-zone strobe length fields |
| cfg_trail | input | 15 | Per-zone hold-off length fields |
| cfg_use_rdy | input | 5 | Per-zone ready enable |
| cfg_rdy_async | input | 5 | Per-zone ready synchronizer select |
| mode_pin | input | 1 | Zone 7 enable loaded at reset |
| mode_we | input | 1 | Write strobe for zone 7 enable |
| mode_wdata | input | 1 | New zone 7 enable |
| clk_we | input | 1 | Write strobe for bus clock setting |
| clk_div | input | 2 | Bus clock division setting |
| clk_off | input | 1 | Bus clock stop |
| ext_a | output | 19 | External address |
| ext_d_out | output | 16 | External write data |
| ext_d_oe | output | 1 | Data output enable |
| ext_d_in | input | 16 | External read data |
| ext_cs_n | output | 3 | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_rnw | output | 1 | Read-not-write indicator |
| ext_ctl_oe | output | 1 | Enable for address, select and strobe drivers |
| ext_ready | input | 1 | External ready, high = ready |
| ext_hold_n | input | 1 | Active-low bus hold request |
| ext_holda_n | output | 1 | Active-low bus hold grant |
| ext_bclk | output | 1 | Divided bus clock |

## Verification
The hardest case to reach from the ports is a hold request that arrives in the middle of an access while another request is already waiting. The controller must finish both before granting the bus, and it must then keep a third request parked until the hold is withdrawn. The bench gets there by raising the hold request two clocks into a long zone 2 access. It offers the next request in the same cycle as the first response, and it presents a new request while the grant is low. Ready stretching is driven by releasing ready a known number of strobe-low clocks into the cycle, so the strobe length is exact in both the direct and the synchronized paths.

// File: rtl/zbus_pkg.sv
package zbus_pkg;
    localparam int NZONE = 5;
    localparam int NSEL  = 3;
    localparam int ZW    = $clog2(NZONE);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ACTIVE,
        ST_TRAIL,
        ST_HOLD
    } bus_st_e;
endpackage

// File: rtl/zbus_zone_dec.sv
module zbus_zone_dec
    import zbus_pkg::*;
(
    input  logic [2:0]      zone_code,
    input  logic            z7_en,
    output logic [ZW-1:0]   zone_idx,
    output logic [NSEL-1:0] sel_oh,
    output logic            hit
);
    always_comb begin
        zone_idx = '0;
        sel_oh   = '0;
        hit      = 1'b0;
        unique case (zone_code)
            3'd0: begin zone_idx = ZW'(0); sel_oh = NSEL'(1); hit = 1'b1;  end
            3'd1: begin zone_idx = ZW'(1); sel_oh = NSEL'(1); hit = 1'b1;  end
            3'd2: begin zone_idx = ZW'(2); sel_oh = NSEL'(2); hit = 1'b1;  end
            3'd6: begin zone_idx = ZW'(3); sel_oh = NSEL'(4); hit = 1'b1;  end
            3'd7: begin zone_idx = ZW'(4); sel_oh = NSEL'(4); hit = z7_en; end
            default: ;
        endcase
    end
endmodule

// File: rtl/zbus_sync2.sv
module zbus_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= RST_VAL;
            q  <= RST_VAL;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/zbus_clkdiv.sv
module zbus_clkdiv (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] div_in,
    input  logic       off_in,
    output logic       bclk_o
);
    logic [1:0] div_q;
    logic       off_q;
    logic [1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= 2'd2;
            off_q <= 1'b0;
            phase <= 2'd0;
        end else begin
            phase <= phase + 2'd1;
            if (we) begin
                div_q <= div_in;
                off_q <= off_in;
            end
        end
    end

    always_comb begin
        if (off_q)              bclk_o = 1'b0;
        else if (div_q == 2'd0) bclk_o = clk;
        else if (div_q == 2'd1) bclk_o = phase[0];
        else                    bclk_o = phase[1];
    end

    // R11: in half-rate mode the output flips on every system clock
    a_r11_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == 2'd1 && !off_q && $past(div_q) == 2'd1 && !$past(off_q))
        |-> (bclk_o != $past(bclk_o)));
endmodule

// File: rtl/zbus_ext_if.sv
module zbus_ext_if
    import zbus_pkg::*;
#(
    parameter int AW = 19,
    parameter int DW = 16,
    parameter int PW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [2:0]          req_zone,
    input  logic [AW-1:0]       req_addr,
    input  logic [DW-1:0]       req_wdata,
    output logic                rsp_valid,
    output logic [DW-1:0]       rsp_rdata,
    input  logic [NZONE*PW-1:0] cfg_lead,
    input  logic [NZONE*PW-1:0] cfg_active,
    input  logic [NZONE*PW-1:0] cfg_trail,
    input  logic [NZONE-1:0]    cfg_use_rdy,
    input  logic [NZONE-1:0]    cfg_rdy_async,
    input  logic                mode_pin,
    input  logic                mode_we,
    input  logic                mode_wdata,
    input  logic                clk_we,
    input  logic [1:0]          clk_div,
    input  logic                clk_off,
    output logic [AW-1:0]       ext_a,
    output logic [DW-1:0]       ext_d_out,
    output logic                ext_d_oe,
    input  logic [DW-1:0]       ext_d_in,
    output logic [NSEL-1:0]     ext_cs_n,
    output logic                ext_rd_n,
    output logic                ext_wr_n,
    output logic                ext_rnw,
    output logic                ext_ctl_oe,
    input  logic                ext_ready,
    input  logic                ext_hold_n,
    output logic                ext_holda_n,
    output logic                ext_bclk
);
    logic [PW-1:0] lead_a [NZONE];
    logic [PW-1:0] act_a  [NZONE];
    logic [PW-1:0] trl_a  [NZONE];

    genvar g;
    generate
        for (g = 0; g < NZONE; g++) begin : g_cfg
            assign lead_a[g] = cfg_lead[g*PW +: PW];
            assign act_a[g]  = cfg_active[g*PW +: PW];
            assign trl_a[g]  = cfg_trail[g*PW +: PW];
        end
    endgenerate

    bus_st_e        st, st_n;
    logic [PW-1:0]  cnt, cnt_n;
    logic [AW-1:0]  a_q;
    logic [DW-1:0]  wd_q, rd_q;
    logic           wr_q, rsp_q, mode_q;
    logic [ZW-1:0]  idx_q, dec_idx;
    logic [NSEL-1:0] sel_q, dec_sel;
    logic           dec_hit, accept, skip, cap, finish;
    logic           rdy_sync, hold_sync, hold_req, rdy_ok, use_sel, busy;

    zbus_zone_dec u_dec (
        .zone_code (req_zone),
        .z7_en     (mode_q),
        .zone_idx  (dec_idx),
        .sel_oh    (dec_sel),
        .hit       (dec_hit)
    );

    zbus_sync2 #(.RST_VAL(1'b0)) u_rdy_sync (
        .clk (clk), .rst_n (rst_n), .d (ext_ready), .q (rdy_sync)
    );

    zbus_sync2 #(.RST_VAL(1'b1)) u_hold_sync (
        .clk (clk), .rst_n (rst_n), .d (ext_hold_n), .q (hold_sync)
    );

    zbus_clkdiv u_clk (
        .clk (clk), .rst_n (rst_n), .we (clk_we),
        .div_in (clk_div), .off_in (clk_off), .bclk_o (ext_bclk)
    );

    assign hold_req = ~hold_sync;
    assign use_sel  = cfg_use_rdy[idx_q];
    assign rdy_ok   = cfg_rdy_async[idx_q] ? rdy_sync : ext_ready;

    // next state
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        accept = 1'b0;
        skip   = 1'b0;
        cap    = 1'b0;
        finish = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (dec_hit) begin
                        st_n  = ST_LEAD;
                        cnt_n = lead_a[dec_idx];
                    end else begin
                        skip = 1'b1;
                    end
                end else if (hold_req) begin
                    st_n = ST_HOLD;
                end
            end
            ST_LEAD: begin
                if (cnt == '0) begin
                    st_n  = ST_ACTIVE;
                    cnt_n = act_a[idx_q];
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (cnt != '0) begin
                    cnt_n = cnt - 1'b1;
                end else if (!use_sel || rdy_ok) begin
                    st_n  = ST_TRAIL;
                    cnt_n = trl_a[idx_q];
                    cap   = 1'b1;
                end
            end
            ST_TRAIL: begin
                if (cnt == '0) begin
                    st_n   = ST_IDLE;
                    finish = 1'b1;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (!hold_req) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // request capture and response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            wd_q   <= '0;
            wr_q   <= 1'b0;
            idx_q  <= '0;
            sel_q  <= '0;
            rd_q   <= '0;
            rsp_q  <= 1'b0;
            mode_q <= mode_pin;
        end else begin
            if (mode_we) mode_q <= mode_wdata;
            rsp_q <= finish | skip;
            if (accept) begin
                a_q   <= req_addr;
                wd_q  <= req_wdata;
                wr_q  <= req_write;
                idx_q <= dec_idx;
                sel_q <= dec_sel;
            end
            if (cap)       rd_q <= ext_d_in;
            else if (skip) rd_q <= '0;
        end
    end

    // outputs
    always_comb begin
        busy        = (st == ST_LEAD) || (st == ST_ACTIVE) || (st == ST_TRAIL);
        ext_cs_n    = busy ? ~sel_q : '1;
        ext_rd_n    = !((st == ST_ACTIVE) && !wr_q);
        ext_wr_n    = !((st == ST_ACTIVE) && wr_q);
        ext_rnw     = !(busy && wr_q);
        ext_d_oe    = busy && wr_q;
        ext_ctl_oe  = (st != ST_HOLD);
        ext_holda_n = (st != ST_HOLD);
        req_ready   = (st == ST_IDLE);
        ext_a       = a_q;
        ext_d_out   = wd_q;
        rsp_valid   = rsp_q;
        rsp_rdata   = rd_q;
    end

    // R4: strobes never low together
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));
    // R2: at most one select low
    a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));
    // R3: a strobe only falls after the select was already low for a clock
    a_r3_lead_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ext_rd_n) || $fell(ext_wr_n)) |-> ($past(ext_cs_n) != '1));
    // R5: write strobe implies write indication
    a_r5_rnw_write: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_wr_n |-> !ext_rnw);
    // R8: a not-ready expired strobe stays in ACTIVE
    a_r8_ready_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE && cnt == '0 && use_sel && !rdy_ok) |=> (st == ST_ACTIVE));
    // R9: grant only from an idle bus, with drivers floated
    a_r9_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_holda_n) |-> ($past(ext_cs_n) == '1 && !ext_ctl_oe && !ext_d_oe));
endmodule

// File: tb/zbus_ext_if_tb.sv
`timescale 1ns/1ps
module zbus_ext_if_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [2:0] req_zone = 0;
    logic [18:0] req_addr = 0;
    logic [15:0] req_wdata = 0;
    logic [14:0] cfg_lead = 0, cfg_active = 0, cfg_trail = 0;
    logic [4:0] cfg_use_rdy = 0, cfg_rdy_async = 0;
    logic mode_pin = 1, mode_we = 0, mode_wdata = 0;
    logic clk_we = 0, clk_off = 0;
    logic [1:0] clk_div = 0;
    logic ext_ready = 1, ext_hold_n = 1;
    logic req_ready, rsp_valid, ext_d_oe, ext_rd_n, ext_wr_n, ext_rnw, ext_ctl_oe, ext_holda_n, ext_bclk;
    logic [15:0] rsp_rdata, ext_d_out, ext_d_in;
    logic [18:0] ext_a;
    logic [2:0] ext_cs_n;

    int nchk = 0, nbad = 0;
    bit g_mode = 1;
    int m_lead, m_act, m_trail, m_cs, m_rd;
    bit m_done, e4, e5, e6;

    always #10 clk = ~clk;
    assign ext_d_in = ext_a[15:0] ^ 16'h5A3C;

    zbus_ext_if u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_zone(req_zone), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .cfg_lead(cfg_lead), .cfg_active(cfg_active),
        .cfg_trail(cfg_trail), .cfg_use_rdy(cfg_use_rdy), .cfg_rdy_async(cfg_rdy_async),
        .mode_pin(mode_pin), .mode_we(mode_we), .mode_wdata(mode_wdata), .clk_we(clk_we),
        .clk_div(clk_div), .clk_off(clk_off), .ext_a(ext_a), .ext_d_out(ext_d_out),
        .ext_d_oe(ext_d_oe), .ext_d_in(ext_d_in), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_wr_n(ext_wr_n), .ext_rnw(ext_rnw), .ext_ctl_oe(ext_ctl_oe), .ext_ready(ext_ready),
        .ext_hold_n(ext_hold_n), .ext_holda_n(ext_holda_n), .ext_bclk(ext_bclk)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int zidx(input logic [2:0] z);
        case (z)
            3'd0: return 0; 3'd1: return 1; 3'd2: return 2;
            3'd6: return 3; 3'd7: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic int zsel(input logic [2:0] z);
        return (z <= 3'd1) ? 0 : (z == 3'd2) ? 1 : 2;
    endfunction

    function automatic int fld(input logic [14:0] v, input int i);
        return int'((v >> (i * 3)) & 15'd7);
    endfunction

    // drive one request from a negedge; measure phases at negedges; return at the response negedge
    task automatic run_access(input bit wr, input logic [2:0] zone, input logic [18:0] addr,
                              input logic [15:0] wd, input int rel);
        int guard;
        bit seen;
        m_lead = 0; m_act = 0; m_trail = 0; m_cs = -1; m_rd = -1; m_done = 0;
        e4 = 0; e5 = 0; e6 = 0; seen = 0;
        req_valid = 1; req_write = wr; req_zone = zone; req_addr = addr; req_wdata = wd;
        guard = 0;
        while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
        @(negedge clk);
        req_valid = 0;
        guard = 0;
        while (!m_done && guard < 300) begin
            if (rsp_valid) begin
                m_done = 1;
                m_rd = int'(rsp_rdata);
            end else begin
                if (ext_cs_n != 3'b111) begin
                    for (int k = 0; k < 3; k++) if (!ext_cs_n[k]) m_cs = k;
                    if (ext_a != addr) e6 = 1;
                    if (ext_d_oe !== wr) e6 = 1;
                    if (wr && ext_d_out != wd) e6 = 1;
                    if (ext_rnw !== !wr) e5 = 1;
                    if (!ext_rd_n || !ext_wr_n) begin
                        m_act++;
                        seen = 1;
                        if ((wr && !ext_rd_n) || (!wr && !ext_wr_n)) e4 = 1;
                        if (rel != 0 && m_act == rel) ext_ready = 1;
                    end else if (!seen) m_lead++;
                    else m_trail++;
                end else if (ext_rnw !== 1'b1 || !ext_rd_n || !ext_wr_n) begin
                    e5 = 1;
                end
                @(negedge clk);
                guard++;
            end
        end
    endtask

    task automatic check_access(input bit wr, input logic [2:0] zone, input logic [18:0] addr,
                                input int exp_act);
        int zi;
        bit hit;
        zi = zidx(zone);
        hit = (zi >= 0) && !(zone == 3'd7 && !g_mode);
        chk("R7 response pulse seen", int'(m_done), 1);
        if (hit) begin
            chk("R2 select line", m_cs, zsel(zone));
            chk("R3 lead length", m_lead, fld(cfg_lead, zi) + 1);
            chk("R3/R8 strobe length", m_act, (exp_act < 0) ? fld(cfg_active, zi) + 1 : exp_act);
            chk("R3 trail length", m_trail, fld(cfg_trail, zi) + 1);
            chk("R4 strobe choice", int'(e4), 0);
            chk("R5 read-not-write", int'(e5), 0);
            chk("R6 address/data drive", int'(e6), 0);
            if (!wr) chk("R7 read data", m_rd, int'(addr[15:0] ^ 16'h5A3C));
        end else begin
            chk("R2 or R12 no select", m_cs, -1);
            chk("R2 or R12 no phases", m_lead + m_act + m_trail, 0);
            chk("R2 or R12 zero data", m_rd, 0);
        end
    endtask

    task automatic clk_measure(output int changes, output int highs);
        logic prev;
        bit first;
        changes = 0; highs = 0; first = 1; prev = 0;
        for (int i = 0; i < 32; i++) begin
            if (i % 2 == 0) begin @(posedge clk); #5; end
            else begin @(negedge clk); #5; end
            if (ext_bclk) highs++;
            if (!first && ext_bclk != prev) changes++;
            prev = ext_bclk;
            first = 0;
        end
        @(negedge clk);
    endtask

    task automatic set_clk(input logic [1:0] d, input logic off);
        @(negedge clk);
        clk_div = d; clk_off = off; clk_we = 1;
        @(negedge clk);
        clk_we = 0;
    endtask

    initial begin
        #(20 * 150000);
        nbad++;
        $display("FAIL R9 watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        int ch, hi, k, cnt_q;
        logic [2:0] zl [5];
        void'($urandom(32'd4711));
        zl[0] = 3'd0; zl[1] = 3'd1; zl[2] = 3'd2; zl[3] = 3'd6; zl[4] = 3'd7;

        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 selects idle", int'(ext_cs_n), 7);
        chk("R1 strobes idle", int'({ext_rd_n, ext_wr_n, ext_rnw}), 7);
        chk("R1 grant idle", int'(ext_holda_n), 1);
        chk("R1 drivers", int'({ext_ctl_oe, ext_d_oe}), 2);
        chk("R1 port ready", int'({req_ready, rsp_valid}), 2);
        // R11 reset rate is a quarter
        clk_measure(ch, hi);
        chk("R11 quarter rate highs", hi, 16);
        chk("R11 quarter rate edges", (ch == 7 || ch == 8) ? ch : -ch, (ch == 7 || ch == 8) ? ch : 8);

        // directed accesses, one per zone and both directions (R2 R3 R4 R5 R6 R7)
        cfg_lead   = {3'd4, 3'd0, 3'd3, 3'd7, 3'd1};
        cfg_active = {3'd0, 3'd5, 3'd3, 3'd2, 3'd1};
        cfg_trail  = {3'd2, 3'd6, 3'd3, 3'd0, 3'd4};
        foreach (zl[i]) begin
            run_access(1'b1, zl[i], 19'h4_1230 + 19'(i), 16'hC0DE + 16'(i), 0);
            check_access(1'b1, zl[i], 19'h4_1230 + 19'(i), -1);
            run_access(1'b0, zl[i], 19'h7_FF00 - 19'(i), 16'h0, 0);
            check_access(1'b0, zl[i], 19'h7_FF00 - 19'(i), -1);
        end
        // R2 invalid zone codes
        run_access(1'b0, 3'd3, 19'h1_2345, 16'h0, 0); check_access(1'b0, 3'd3, 19'h1_2345, -1);
        run_access(1'b1, 3'd5, 19'h0_0077, 16'h9999, 0); check_access(1'b1, 3'd5, 19'h0_0077, -1);

        // R8 ready handling on zone 2 (field 2) with strobe count 2
        cfg_active = {3'd0, 3'd5, 3'd1, 3'd2, 3'd1};
        cfg_use_rdy = 5'b00100; cfg_rdy_async = 5'b00000;
        ext_ready = 0; repeat (3) @(negedge clk);
        run_access(1'b0, 3'd2, 19'h0_0ABC, 16'h0, 6);
        check_access(1'b0, 3'd2, 19'h0_0ABC, 6);
        cfg_rdy_async = 5'b00100;
        ext_ready = 0; repeat (3) @(negedge clk);
        run_access(1'b1, 3'd2, 19'h0_0ABD, 16'h1357, 6);
        check_access(1'b1, 3'd2, 19'h0_0ABD, 8);
        // R8 ready ignored on zone 1
        ext_ready = 0; repeat (3) @(negedge clk);
        run_access(1'b0, 3'd1, 19'h0_0ABE, 16'h0, 0);
        check_access(1'b0, 3'd1, 19'h0_0ABE, -1);
        ext_ready = 1; cfg_use_rdy = 0; cfg_rdy_async = 0;
        repeat (3) @(negedge clk);

        // random accesses with random timing
        for (int i = 0; i < 40; i++) begin
            logic [2:0] z;
            logic [18:0] ad;
            logic [15:0] wdv;
            bit w;
            cfg_lead = 15'($urandom); cfg_active = 15'($urandom); cfg_trail = 15'($urandom);
            cfg_use_rdy = 5'($urandom); cfg_rdy_async = 5'($urandom);
            z = zl[$urandom % 5]; ad = 19'($urandom); wdv = 16'($urandom); w = 1'($urandom);
            run_access(w, z, ad, wdv, 0);
            check_access(w, z, ad, -1);
        end
        cfg_use_rdy = 0;

        // R12 software clears zone 7 enable
        mode_we = 1; mode_wdata = 0; @(negedge clk); mode_we = 0; g_mode = 0;
        run_access(1'b0, 3'd7, 19'h5_5555, 16'h0, 0); check_access(1'b0, 3'd7, 19'h5_5555, -1);
        run_access(1'b0, 3'd6, 19'h5_5556, 16'h0, 0); check_access(1'b0, 3'd6, 19'h5_5556, -1);
        mode_we = 1; mode_wdata = 1; @(negedge clk); mode_we = 0; g_mode = 1;
        run_access(1'b0, 3'd7, 19'h5_5557, 16'h0, 0); check_access(1'b0, 3'd7, 19'h5_5557, -1);

        // R9 hold during an access with a second request waiting
        cfg_lead = {15{1'b0}} | (15'd3 << 6); cfg_active = (15'd3 << 6); cfg_trail = (15'd3 << 6);
        fork
            begin
                run_access(1'b1, 3'd2, 19'h0_0100, 16'h1111, 0);
                check_access(1'b1, 3'd2, 19'h0_0100, -1);
                run_access(1'b0, 3'd6, 19'h0_0200, 16'h0, 0);
                check_access(1'b0, 3'd6, 19'h0_0200, -1);
            end
            begin
                @(negedge clk); @(negedge clk);
                ext_hold_n = 0;
            end
        join
        @(negedge clk);
        chk("R9 grant given", int'(ext_holda_n), 0);
        chk("R9 drivers floated", int'({ext_ctl_oe, ext_d_oe}), 0);
        fork
            begin
                run_access(1'b1, 3'd0, 19'h0_0321, 16'hBEEF, 0);
                check_access(1'b1, 3'd0, 19'h0_0321, -1);
            end
            begin
                cnt_q = 0;
                for (int j = 0; j < 5; j++) begin
                    if (!req_ready && ext_cs_n == 3'b111 && !ext_ctl_oe) cnt_q++;
                    @(negedge clk);
                end
                chk("R9 request parked during grant", cnt_q, 5);
                ext_hold_n = 1;
                k = 0;
                while (!ext_holda_n && k < 10) begin @(negedge clk); k++; end
                chk("R10 grant release delay", k, 3);
            end
        join

        // R11 rates and stop
        set_clk(2'd0, 1'b0); clk_measure(ch, hi);
        chk("R11 full rate edges", ch, 31); chk("R11 full rate highs", hi, 16);
        set_clk(2'd1, 1'b0); clk_measure(ch, hi);
        chk("R11 half rate edges", ch, 15); chk("R11 half rate highs", hi, 16);
        set_clk(2'd1, 1'b1); clk_measure(ch, hi);
        chk("R11 stopped highs", hi, 0);

        // R12 enable loaded low from the pin at reset
        @(negedge clk);
        rst_n = 0; mode_pin = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; g_mode = 0;
        @(negedge clk);
        run_access(1'b1, 3'd7, 19'h6_0001, 16'h2222, 0); check_access(1'b1, 3'd7, 19'h6_0001, -1);
        clk_measure(ch, hi);
        chk("R11 reset returns to quarter rate", hi, 16);

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule